// File: doc/BRIEF.md
# Flash Protection and Status Unit

This block holds the protection setting and the command status flags of a small on-chip flash controller. While reset is held, it copies a protection byte from a nonvolatile shadow input. After that the byte changes only through a separate debug write path. The CPU may read the protection byte but cannot change it.

Each incoming program or erase request carries a flash address. The block compares that address against the boundary given by the protection byte. A request aimed at the locked high-address region is dropped and raises a sticky violation flag. Any other request is passed on, one cycle later, to the command stage that follows.

The CPU reads the status byte over the same register bus and clears its error flags by writing ones to them.

Top module: `flash_guard`

## Requirements
- R1: While `rst` is high at a clock edge, the protection byte is loaded from `nv_prot`. A debug write in the same cycle is discarded.
- R2: CPU writes with `cpu_sel`=0 leave the protection byte unchanged. A read with `cpu_sel`=0 returns the stored protection byte on `cpu_rdata` after the next edge.
- R3: A `dbg_wr` pulse outside reset replaces the protection byte with `dbg_wdata`.
- R4: When bit 0 of the protection byte (the disable flag) is 1, every request is forwarded, including address 0xFFFF.
- R5: When the disable flag is 0, the last open address is {prot[7:1], 9'h1FF}. That address and every lower one are forwarded. Every address strictly above it is locked.
- R6: A request to a locked address produces no `cmd_valid` and sets the violation flag (status bit 5) at the next edge.
- R7: After reset the status byte reads 0xC0. Bit 7 is the buffer-empty flag, bit 6 is the complete flag, bit 5 is the violation flag, bit 4 is the access-error flag and bit 2 is the blank flag.
- R8: Status bits 3, 1 and 0 always read 0, even after a write of 0xFF.
- R9: A CPU write with `cpu_sel`=1 and a 1 in bit 5 or bit 4 clears that flag. A 0 in those bits leaves the flag as it was. If a violation is set and cleared in the same cycle, the set wins.
- R10: A forwarded request appears on `cmd_valid`/`cmd_addr` exactly one cycle after it is presented, with the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nv_prot | input | 8 | Nonvolatile protection byte, loaded during reset |
| cpu_sel | input | 1 | Register select: 0 protection, 1 status |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Registered read data of the selected register |
| dbg_wr | input | 1 | Debug write strobe for the protection byte |
| dbg_wdata | input | 8 | Debug write data |
| req_valid | input | 1 | Program or erase request strobe |
| req_addr | input | 16 | Target flash address of the request |
| cmd_valid | output | 1 | Forwarded request strobe |
| cmd_addr | output | 16 | Forwarded request address |

## Verification
The lock decision is tried with several addresses. The exact boundary address is forwarded, while the one just above it is locked, which catches an off-by-one in the compare. Address zero and the top address check both ends of the range.

The boundary is also moved through debug writes, to the widest and the narrowest open region. The disable flag is set while a top address is requested, which shows that the flag overrides the field. Writing zeros and then ones to the status register separates clear-on-one from plain overwrite. It also shows that the reserved bits stay zero.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int ADDR_W = 16;
  localparam int FPS_W  = 7;
  localparam int BYTE_W = FPS_W + 1;
  localparam int LOW_W  = ADDR_W - FPS_W;

  localparam int BIT_BUF_EMPTY = 7;
  localparam int BIT_DONE      = 6;
  localparam int BIT_VIOL      = 5;
  localparam int BIT_ACCERR    = 4;
  localparam int BIT_BLANK     = 2;

  typedef enum logic {SEL_PROT = 1'b0, SEL_STAT = 1'b1} reg_sel_e;
endpackage

// File: rtl/fg_prot_reg.sv
module fg_prot_reg
  import flash_guard_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] nv_byte,
  input  logic         dbg_wr,
  input  logic [W-1:0] dbg_data,
  output logic [W-1:0] prot
);
  always_ff @(posedge clk) begin
    if (rst)         prot <= nv_byte;
    else if (dbg_wr) prot <= dbg_data;
  end

  AST_RESET_LOAD: assert property (@(posedge clk)
    rst |=> prot == $past(nv_byte)); // R1

  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !dbg_wr |=> $stable(prot)); // R2

  AST_DBG_LOAD: assert property (@(posedge clk) disable iff (rst)
    dbg_wr |=> prot == $past(dbg_data)); // R3
endmodule

// File: rtl/fg_region_check.sv
module fg_region_check
  import flash_guard_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int FW = FPS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW:0]   prot,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          hit_locked,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr
);
  localparam int LW = AW - FW;

  logic [AW-1:0] last_open;
  logic          locked;

  assign last_open  = {prot[FW:1], {LW{1'b1}}};
  assign locked     = !prot[0] && (req_addr > last_open);
  assign hit_locked = req_valid && locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
    end else begin
      cmd_valid <= req_valid && !locked;
      if (req_valid && !locked) cmd_addr <= req_addr;
    end
  end

  AST_NO_FWD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    hit_locked |=> !cmd_valid); // R6

  AST_DISABLE_OPEN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && prot[0]) |=> cmd_valid); // R4

  AST_CMD_ADDR: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_addr == $past(req_addr) && $past(req_valid))); // R10
endmodule

// File: rtl/fg_status_reg.sv
module fg_status_reg
  import flash_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       viol_set,
  input  logic       wr_en,
  input  logic [1:0] clr_bits,
  output logic [7:0] stat
);
  logic buf_empty, done, viol, accerr, blank;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_empty <= 1'b1;
      done      <= 1'b1;
      viol      <= 1'b0;
      accerr    <= 1'b0;
      blank     <= 1'b0;
    end else begin
      if (viol_set)                  viol   <= 1'b1;
      else if (wr_en && clr_bits[1]) viol   <= 1'b0;
      if (wr_en && clr_bits[0])      accerr <= 1'b0;
    end
  end

  always_comb begin
    stat                = 8'h00;
    stat[BIT_BUF_EMPTY] = buf_empty;
    stat[BIT_DONE]      = done;
    stat[BIT_VIOL]      = viol;
    stat[BIT_ACCERR]    = accerr;
    stat[BIT_BLANK]     = blank;
  end

  AST_VIOL_SET: assert property (@(posedge clk) disable iff (rst)
    viol_set |=> viol); // R6

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (viol && !(wr_en && clr_bits[1])) |=> viol); // R9

  AST_VIOL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && clr_bits[1] && !viol_set) |=> !viol); // R9
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] nv_prot,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              dbg_wr,
  input  logic [BYTE_W-1:0] dbg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr
);
  logic [BYTE_W-1:0] prot;
  logic [7:0]        stat;
  logic              hit_locked;
  logic              stat_wr;

  assign stat_wr = cpu_wr && (reg_sel_e'(cpu_sel) == SEL_STAT);

  fg_prot_reg #(.W(BYTE_W)) u_prot (
    .clk(clk), .rst(rst), .nv_byte(nv_prot),
    .dbg_wr(dbg_wr), .dbg_data(dbg_wdata), .prot(prot)
  );

  fg_region_check #(.AW(ADDR_W), .FW(FPS_W)) u_region (
    .clk(clk), .rst(rst), .prot(prot),
    .req_valid(req_valid), .req_addr(req_addr),
    .hit_locked(hit_locked), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr)
  );

  fg_status_reg u_stat (
    .clk(clk), .rst(rst), .viol_set(hit_locked), .wr_en(stat_wr),
    .clr_bits({cpu_wdata[BIT_VIOL], cpu_wdata[BIT_ACCERR]}), .stat(stat)
  );

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= 8'h00;
    else     cpu_rdata <= (reg_sel_e'(cpu_sel) == SEL_STAT) ? stat : 8'(prot);
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cpu_sel == 1'b1) |=> (cpu_rdata & 8'h0B) == 8'h00); // R8
endmodule

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  nv_prot = 8'h80;
  logic        cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = 8'h00, cpu_rdata;
  logic        dbg_wr = 1'b0;
  logic [7:0]  dbg_wdata = 8'h00;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = 16'h0000;
  logic        cmd_valid;
  logic [15:0] cmd_addr;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];

  always #4 clk = ~clk;

  flash_guard u0 (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected forwarded addresses
  always @(negedge clk) begin
    if (!rst && cmd_valid) begin
      if (exp_q.size() == 0) check("R6 unexpected cmd", cmd_addr, 16'hxxxx);
      else check("R10 cmd_addr", cmd_addr, exp_q.pop_front());
    end
  end

  task automatic send_req(input logic [15:0] a, input bit fwd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    if (fwd) exp_q.push_back(a);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_reg(input logic sel, input logic [7:0] exp, input string req);
    @(negedge clk);
    cpu_sel = sel; cpu_wr = 1'b0;
    @(negedge clk);
    check(req, {8'h00, cpu_rdata}, {8'h00, exp});
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cpu_sel = sel; cpu_wr = 1'b1; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic dbg_write(input logic [7:0] d);
    @(negedge clk);
    dbg_wr = 1'b1; dbg_wdata = d;
    @(negedge clk);
    dbg_wr = 1'b0;
  endtask

  task automatic queue_empty(input string req);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s actual=%0d pending expected=0", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset wins over a simultaneous debug write
    dbg_wr = 1'b1; dbg_wdata = 8'h11;
    repeat (3) @(negedge clk);
    dbg_wr = 1'b0; rst = 1'b0;
    read_reg(1'b0, 8'h80, "R1 reset load");
    read_reg(1'b1, 8'hC0, "R7 status reset");

    // R5: boundary 0x81FF
    send_req(16'h81FF, 1'b1);
    send_req(16'h0000, 1'b1);
    queue_empty("R5 open addresses forwarded");
    send_req(16'h8200, 1'b0);
    queue_empty("R6 locked not forwarded");
    read_reg(1'b1, 8'hE0, "R6 violation flag");
    send_req(16'hFFFF, 1'b0);

    // R9: write zero keeps, write one clears; R8 reserved stay zero
    write_reg(1'b1, 8'h00);
    read_reg(1'b1, 8'hE0, "R9 write 0 keeps flag");
    write_reg(1'b1, 8'hFF);
    read_reg(1'b1, 8'hC0, "R9 R8 write 1 clears, reserved zero");

    // R2: CPU write to protection ignored
    write_reg(1'b0, 8'h55);
    read_reg(1'b0, 8'h80, "R2 cpu write ignored");
    send_req(16'h8200, 1'b0);
    queue_empty("R2 boundary unchanged");

    // R3: debug widest open region
    dbg_write(8'hFE);
    read_reg(1'b0, 8'hFE, "R3 debug write");
    send_req(16'hFFFF, 1'b1);
    queue_empty("R5 widest region top forwarded");

    // narrowest region
    dbg_write(8'h00);
    send_req(16'h01FF, 1'b1);
    send_req(16'h0200, 1'b0);
    queue_empty("R5 narrow boundary");

    // R4: disable flag
    write_reg(1'b1, 8'h20);
    dbg_write(8'h01);
    send_req(16'hFFFF, 1'b1);
    queue_empty("R4 disabled forwards top");
    read_reg(1'b1, 8'hC0, "R4 no violation when disabled");

    // R9: set wins over simultaneous clear
    dbg_write(8'h00);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'hF000;
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_wdata = 8'h20;
    @(negedge clk);
    req_valid = 1'b0; cpu_wr = 1'b0;
    read_reg(1'b1, 8'hE0, "R9 set beats clear");
    queue_empty("R6 no forward on locked");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule